// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

A single DMA channel that walks a linked list of command descriptors held in memory. Each descriptor is a small record of 32-bit words: a link to the following descriptor, a packed command word, a buffer address and up to fifteen programmed-I/O (PIO) words. For each descriptor the engine first copies the PIO words to a peripheral's register file. It then moves the data: memory to the peripheral stream, the peripheral stream to memory, or nothing.

Processing is gated by a hardware semaphore. Software adds any count to it through a strobe and can read it back at all times. The channel runs only while the count is non-zero. A command that completes with its decrement flag set lowers the count by one. Software first loads a descriptor pointer, which arms the channel, and then feeds the semaphore. A command whose link flag is clear disarms the channel once it completes.

A freeze input makes the channel lose every bus and stream handshake without losing state. An abort input drops the channel back to idle. A sticky interrupt flag with its own enable and acknowledge reports completed commands.

FSM states:
- `ST_IDLE`: waiting.
- `ST_LINK`, `ST_CMD`, `ST_BUF`: fetch the three descriptor header words.
- `ST_PIO_RD`, `ST_PIO_WR`: fetch a PIO word, then hand it to the peripheral.
- `ST_MEM_RD`, `ST_PUSH`: read a word from memory, then emit it on the stream.
- `ST_PULL`, `ST_MEM_WR`: take a word from the stream, then write it to memory.
- `ST_DONE`: completion.

Transitions:
- IDLE to LINK when the channel is armed, the count is non-zero and freeze is low.
- Each fetch state advances on an unfrozen grant.
- BUF goes to PIO_RD if the PIO count is non-zero, otherwise to the data entry.
- The data entry is MEM_RD for kind 2, PULL for kind 1, and DONE for the other kinds or a zero byte count.
- PIO_WR loops back to PIO_RD until the last PIO word, then goes to the data entry.
- PUSH returns to MEM_RD, and MEM_WR returns to PULL, until the last word; then both go to DONE.
- DONE goes to IDLE.
- Abort forces IDLE from any state.

Top module: `dma_chain_engine`

## Requirements
- R1: The command word has these fields:
  - bits [1:0]: the transfer kind.
  - bit 2: link.
  - bit 3: interrupt-on-complete.
  - bit 6: decrement.
  - bits [15:12]: PIO word count.
  - bits [31:16]: byte count.
  - Bits 4, 5, 7, 8, 9, 10 and 11 have no effect on the engine.
- R2: A descriptor at byte address P holds the link at P, the command word at P+4, the buffer address at P+8 and PIO word i at P+12+4i. The low three bits of a loaded pointer and of a fetched link are forced to zero.
- R3: After reset the engine is idle with a zero count, no pending interrupt and no bus request. It leaves idle only when armed and the count is non-zero, so a chained descriptor is not started while the count is zero.
- R4: Completing a command lowers the count by exactly one if its decrement flag is set, and leaves it unchanged otherwise.
- R5: A strobe adds an arbitrary value to the count, which reads back on `sema_count` one cycle later. The sum saturates at the all-ones value.
- R6: The PIO words are written in descriptor order to peripheral register indices 0 up to n-1, where n is the PIO count. All of them are written before any data word moves.
- R7: Kind 2 reads ceil(bytes/4) consecutive words starting at the buffer address and emits each one on the stream output.
- R8: Kind 1 takes ceil(bytes/4) words from the stream input and writes them to consecutive words starting at the buffer address.
- R9: Kind 0, kind 3 and a zero byte count skip the data phase. The command still completes, including its decrement and interrupt.
- R10: With the link flag set, the engine goes on to the linked descriptor while the count stays non-zero. With it clear, the engine disarms and stays idle until a new pointer is loaded.
- R11: A completed command with the interrupt flag sets a sticky pending flag. `irq` equals pending AND enable. An acknowledge clears the flag, and a new completion in the same cycle wins.
- R12: While freeze is high there is no memory request, PIO write or stream handshake, and the state and count are held. After release the work finishes with the same results.
- R13: An abort returns the engine to idle, clears the count and disarms it by the next cycle. A later count alone then does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Synchronous abort: idle, count cleared, disarmed |
| freeze | input | 1 | Withholds every handshake while high |
| ptr_load | input | 1 | Load descriptor pointer and arm |
| ptr_value | input | AW | Descriptor pointer |
| sema_add | input | 1 | Add strobe for the semaphore |
| sema_add_val | input | SEMA_W | Amount to add |
| sema_count | output | SEMA_W | Current semaphore count |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Write-one acknowledge of the pending flag |
| irq_pending | output | 1 | Sticky completion flag |
| irq | output | 1 | Pending AND enable |
| busy | output | 1 | Engine is not idle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| pio_wr | output | 1 | Peripheral register write strobe |
| pio_idx | output | 4 | Peripheral register index |
| pio_data | output | 32 | Peripheral register data |
| st_out_valid | output | 1 | Stream word to the peripheral |
| st_out_data | output | 32 | Stream output data |
| st_in_ready | output | 1 | Engine accepts a stream word |
| st_in_valid | input | 1 | Peripheral offers a stream word |
| st_in_data | input | 32 | Stream input data |

## Verification
The hardest situation to reach from the ports is a linked descriptor that is ready to run while the count has just run out. The channel must stay armed but idle there, and resume at the right link when the count is raised again. The stimulus builds a two-descriptor chain, grants a count of one, and checks that only the first descriptor's words appear. It then adds one more and expects exactly the second descriptor's words. A freeze raised in the middle of a read transfer, with grants stalled every third cycle, covers the held-state case.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PIO_IDX_W  = 4;
    localparam int unsigned BYTE_CNT_W = 16;
    localparam int unsigned WORD_CNT_W = BYTE_CNT_W - 1;

    typedef enum logic [1:0] {
        XF_NONE     = 2'd0,
        XF_TO_MEM   = 2'd1,
        XF_FROM_MEM = 2'd2,
        XF_SENSE    = 2'd3
    } xfer_t;

    // Packed most significant field first; kind sits in bits [1:0].
    typedef struct packed {
        logic [BYTE_CNT_W-1:0] nbytes;
        logic [PIO_IDX_W-1:0]  npio;
        logic [1:0]            rsvd;
        logic                  flush;
        logic                  halt_term;
        logic                  wait_end;
        logic                  dec_sem;
        logic                  wait_rdy;
        logic                  lock;
        logic                  irq;
        logic                  chain;
        xfer_t                 kind;
    } dcmd_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LINK,
        ST_CMD,
        ST_BUF,
        ST_PIO_RD,
        ST_PIO_WR,
        ST_MEM_RD,
        ST_PUSH,
        ST_PULL,
        ST_MEM_WR,
        ST_DONE
    } dstate_t;

endpackage

// File: rtl/dmac_sema.sv
module dmac_sema #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [CW-1:0] add_val,
    input  logic          dec,
    output logic [CW-1:0] cnt
);
    localparam logic [CW+1:0] MAXV = {2'b00, {CW{1'b1}}};

    logic [CW+1:0] wide;
    logic [CW-1:0] cnt_d;

    always_comb begin
        wide = {2'b00, cnt} + (add ? {2'b00, add_val} : '0);
        if (dec && (wide != '0)) begin
            wide = wide - 1'b1;
        end
        cnt_d = (wide > MAXV) ? {CW{1'b1}} : wide[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !add && !clr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    a_r5_add_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !dec && !clr && ({1'b0, cnt} + {1'b0, add_val}) <= {1'b0, {CW{1'b1}}})
        |=> cnt == $past(cnt) + $past(add_val));

    a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

endmodule

// File: rtl/dmac_irq.sv
module dmac_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    input  logic en,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    assign irq = pending & en;

    a_r11_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pending);

    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !pending);

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dmac_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned SEMA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort,
    input  logic                 freeze,
    input  logic                 ptr_load,
    input  logic [AW-1:0]        ptr_value,
    input  logic                 sema_add,
    input  logic [SEMA_W-1:0]    sema_add_val,
    output logic [SEMA_W-1:0]    sema_count,
    input  logic                 irq_en,
    input  logic                 irq_ack,
    output logic                 irq_pending,
    output logic                 irq,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_gnt,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 pio_wr,
    output logic [PIO_IDX_W-1:0] pio_idx,
    output logic [WORD_W-1:0]    pio_data,
    output logic                 st_out_valid,
    output logic [WORD_W-1:0]    st_out_data,
    output logic                 st_in_ready,
    input  logic                 st_in_valid,
    input  logic [WORD_W-1:0]    st_in_data
);
    localparam int unsigned ALIGN_B = 3;
    localparam logic [AW-1:0] OFS_CMD  = AW'(4);
    localparam logic [AW-1:0] OFS_BUF  = AW'(8);
    localparam logic [AW-1:0] OFS_PIO  = AW'(12);
    localparam logic [AW-1:0] WSTEP    = AW'(4);

    dstate_t state_q, state_d;
    dcmd_t   cmd_q;
    logic [AW-1:0]         cur_q, link_q, buf_q;
    logic [PIO_IDX_W-1:0]  pio_q;
    logic [WORD_CNT_W-1:0] left_q;
    logic [WORD_W-1:0]     hold_q;
    logic                  armed_q;

    logic        gnt;
    logic        done_fire;
    dstate_t     data_entry;
    logic [BYTE_CNT_W:0] wsum;
    logic        unused_fields;

    assign gnt       = mem_gnt & mem_req;
    assign done_fire = (state_q == ST_DONE) && !freeze && !abort;
    assign wsum      = {1'b0, cmd_q.nbytes} + (BYTE_CNT_W+1)'(3);
    assign unused_fields = ^{cmd_q.lock, cmd_q.wait_rdy, cmd_q.wait_end,
                             cmd_q.halt_term, cmd_q.flush, cmd_q.rsvd,
                             mem_rdata[ALIGN_B-1:0], ptr_value[ALIGN_B-1:0]};

    // Semaphore and interrupt flag
    dmac_sema #(.CW(SEMA_W)) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (abort),
        .add     (sema_add),
        .add_val (sema_add_val),
        .dec     (done_fire && cmd_q.dec_sem),
        .cnt     (sema_count)
    );

    dmac_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (done_fire && cmd_q.irq),
        .ack     (irq_ack),
        .en      (irq_en),
        .pending (irq_pending),
        .irq     (irq)
    );

    // Where the data phase begins for the current command
    always_comb begin
        if (cmd_q.nbytes == '0) begin
            data_entry = ST_DONE;
        end else begin
            unique case (cmd_q.kind)
                XF_FROM_MEM: data_entry = ST_MEM_RD;
                XF_TO_MEM:   data_entry = ST_PULL;
                default:     data_entry = ST_DONE;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (armed_q && sema_count != '0 && !freeze) state_d = ST_LINK;
            ST_LINK:   if (gnt) state_d = ST_CMD;
            ST_CMD:    if (gnt) state_d = ST_BUF;
            ST_BUF:    if (gnt) state_d = (cmd_q.npio != '0) ? ST_PIO_RD : data_entry;
            ST_PIO_RD: if (gnt) state_d = ST_PIO_WR;
            ST_PIO_WR: if (!freeze)
                           state_d = (pio_q == cmd_q.npio - 1'b1) ? data_entry : ST_PIO_RD;
            ST_MEM_RD: if (gnt) state_d = ST_PUSH;
            ST_PUSH:   if (!freeze)
                           state_d = (left_q == WORD_CNT_W'(1)) ? ST_DONE : ST_MEM_RD;
            ST_PULL:   if (st_in_valid && !freeze) state_d = ST_MEM_WR;
            ST_MEM_WR: if (gnt)
                           state_d = (left_q == WORD_CNT_W'(1)) ? ST_DONE : ST_PULL;
            ST_DONE:   if (!freeze) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            cur_q   <= '0;
            link_q  <= '0;
            buf_q   <= '0;
            pio_q   <= '0;
            left_q  <= '0;
            hold_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE:   pio_q <= '0;
                ST_LINK:   if (gnt) link_q <= {mem_rdata[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
                ST_CMD:    if (gnt) cmd_q <= dcmd_t'(mem_rdata);
                ST_BUF:    if (gnt) begin
                               buf_q  <= mem_rdata[AW-1:0];
                               left_q <= wsum[BYTE_CNT_W:2];
                           end
                ST_PIO_RD: if (gnt) hold_q <= mem_rdata;
                ST_PIO_WR: if (!freeze) pio_q <= pio_q + 1'b1;
                ST_MEM_RD: if (gnt) hold_q <= mem_rdata;
                ST_PUSH:   if (!freeze) begin
                               buf_q  <= buf_q + WSTEP;
                               left_q <= left_q - 1'b1;
                           end
                ST_PULL:   if (st_in_valid && !freeze) hold_q <= st_in_data;
                ST_MEM_WR: if (gnt) begin
                               buf_q  <= buf_q + WSTEP;
                               left_q <= left_q - 1'b1;
                           end
                ST_DONE:   if (!freeze) begin
                               cur_q   <= link_q;
                               armed_q <= cmd_q.chain;
                           end
                default:   ;
            endcase
            if (ptr_load) begin
                cur_q   <= {ptr_value[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
                armed_q <= 1'b1;
            end
            if (abort) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = cur_q;
        pio_wr       = 1'b0;
        st_out_valid = 1'b0;
        st_in_ready  = 1'b0;
        unique case (state_q)
            ST_LINK:   begin mem_req = !freeze; mem_addr = cur_q; end
            ST_CMD:    begin mem_req = !freeze; mem_addr = cur_q + OFS_CMD; end
            ST_BUF:    begin mem_req = !freeze; mem_addr = cur_q + OFS_BUF; end
            ST_PIO_RD: begin
                           mem_req  = !freeze;
                           mem_addr = cur_q + OFS_PIO + AW'({pio_q, 2'b00});
                       end
            ST_PIO_WR: pio_wr = !freeze;
            ST_MEM_RD: begin mem_req = !freeze; mem_addr = buf_q; end
            ST_PUSH:   st_out_valid = !freeze;
            ST_PULL:   st_in_ready = !freeze;
            ST_MEM_WR: begin mem_req = !freeze; mem_we = 1'b1; mem_addr = buf_q; end
            default:   ;
        endcase
    end

    assign mem_wdata   = hold_q;
    assign pio_idx     = pio_q;
    assign pio_data    = hold_q;
    assign st_out_data = hold_q;
    assign busy        = (state_q != ST_IDLE);

    // Checks beside the control logic
    a_r3_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sema_count == '0) |=> state_q == ST_IDLE);

    a_r12_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !abort) |=> (state_q == $past(state_q) && buf_q == $past(buf_q)
                                && left_q == $past(left_q)));

    a_r13_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE && !armed_q));

    a_r6_pio_range: assert property (@(posedge clk) disable iff (!rst_n)
        pio_wr |-> pio_idx < cmd_q.npio);

    a_r10_unlinked_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (done_fire && !cmd_q.chain && !ptr_load) |=> !armed_q);

endmodule

// File: tb/sim_dma_chain_engine.sv
module sim_dma_chain_engine;
    localparam int AW = 32;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort = 0, freeze = 0, ptr_load = 0, sema_add = 0, irq_en = 0, irq_ack = 0;
    logic [AW-1:0] ptr_value = '0;
    logic [SW-1:0] sema_add_val = '0;
    logic [SW-1:0] sema_count;
    logic irq_pending, irq, busy, mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic pio_wr, st_out_valid, st_in_ready, st_in_valid;
    logic [3:0] pio_idx;
    logic [31:0] pio_data, st_out_data, st_in_data;

    always #5 clk = ~clk;

    // Memory model: bench preloads init_mem, engine writes land in dut_mem
    logic [31:0] init_mem [0:1023];
    logic [31:0] dut_mem  [0:1023];
    logic        wr_flag  [0:1023];
    int cyc = 0;
    int in_cnt = 0;
    logic in_en = 0;

    assign mem_gnt    = mem_req && ((cyc % 3) != 2);
    assign mem_rdata  = wr_flag[mem_addr[11:2]] ? dut_mem[mem_addr[11:2]] : init_mem[mem_addr[11:2]];
    assign st_in_valid = in_en;
    assign st_in_data  = 32'hC0DE_0000 + in_cnt;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we && mem_gnt) begin
            dut_mem[mem_addr[11:2]] <= mem_wdata;
            wr_flag[mem_addr[11:2]] <= 1'b1;
        end
        if (st_in_ready && st_in_valid) in_cnt <= in_cnt + 1;
    end

    dma_chain_engine #(.AW(AW), .SEMA_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .abort(abort), .freeze(freeze),
        .ptr_load(ptr_load), .ptr_value(ptr_value),
        .sema_add(sema_add), .sema_add_val(sema_add_val), .sema_count(sema_count),
        .irq_en(irq_en), .irq_ack(irq_ack), .irq_pending(irq_pending), .irq(irq),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .pio_wr(pio_wr), .pio_idx(pio_idx), .pio_data(pio_data),
        .st_out_valid(st_out_valid), .st_out_data(st_out_data),
        .st_in_ready(st_in_ready), .st_in_valid(st_in_valid), .st_in_data(st_in_data)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    bit mon_quiet = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard
    logic [35:0] exp_pio [$];
    logic [31:0] exp_out [$];

    always @(negedge clk) begin
        if (rst_n && !mon_quiet) begin
            if (pio_wr) begin
                if (exp_pio.size() == 0) chk(0, "R6 unexpected PIO write", {pio_idx, pio_data}, 0);
                else begin
                    logic [35:0] e;
                    e = exp_pio.pop_front();
                    chk({pio_idx, pio_data} == e, "R6 PIO write order", {pio_idx, pio_data}, e);
                end
            end
            if (st_out_valid) begin
                if (exp_pio.size() != 0) chk(0, "R6 data before PIO done", exp_pio.size(), 0);
                if (exp_out.size() == 0) chk(0, "R7/R9 unexpected stream word", st_out_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_out.pop_front();
                    chk(st_out_data == e, "R7 stream word", st_out_data, e);
                end
            end
        end
    end

    function automatic logic [31:0] mk_cmd(input int kind, input bit chain, input bit irqb,
                                           input bit dec, input int npio, input int nbytes,
                                           input bit junk);
        logic [31:0] w;
        w = '0;
        w[1:0]   = kind[1:0];
        w[2]     = chain;
        w[3]     = irqb;
        w[6]     = dec;
        w[15:12] = npio[3:0];
        w[31:16] = nbytes[15:0];
        if (junk) w[11:7] = 5'b11111;
        if (junk) w[5:4]  = 2'b11;
        return w;
    endfunction

    task automatic put_desc(input int base, input int nxt, input logic [31:0] cw, input int bufa,
                            input int npio, input logic [31:0] seed, input bit expect_it);
        init_mem[base >> 2]       = nxt;
        init_mem[(base >> 2) + 1] = cw;
        init_mem[(base >> 2) + 2] = bufa;
        for (int i = 0; i < npio; i++) begin
            init_mem[(base >> 2) + 3 + i] = seed + i;
            if (expect_it) exp_pio.push_back({4'(i), seed + 32'(i)});
        end
    endtask

    task automatic fill_buf(input int bufa, input int nwords, input logic [31:0] seed, input bit expect_it);
        for (int i = 0; i < nwords; i++) begin
            init_mem[(bufa >> 2) + i] = seed ^ (32'h1111 * i);
            if (expect_it) exp_out.push_back(seed ^ (32'h1111 * i));
        end
    endtask

    task automatic load_ptr(input int p);
        @(posedge clk); #1;
        ptr_load = 1; ptr_value = p;
        @(posedge clk); #1;
        ptr_load = 0;
    endtask

    task automatic add_sema(input int v);
        @(posedge clk); #1;
        sema_add = 1; sema_add_val = v[SW-1:0];
        @(posedge clk); #1;
        sema_add = 0;
    endtask

    task automatic wait_idle();
        int stable = 0;
        int n = 0;
        while (stable < 4 && n < 5000) begin
            @(negedge clk);
            if (!busy) stable++; else stable = 0;
            n++;
        end
    endtask

    task automatic drain_check(input string tag);
        chk(exp_pio.size() == 0, {tag, " PIO queue drained"}, exp_pio.size(), 0);
        chk(exp_out.size() == 0, {tag, " stream queue drained"}, exp_out.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            init_mem[i] = 32'hDEAD_0000 + i;
            dut_mem[i]  = '0;
            wr_flag[i]  = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R3 reset state
        chk(!busy && sema_count == 0 && !irq_pending && !mem_req, "R3 reset state",
            {busy, irq_pending, mem_req, sema_count}, 0);

        // T1: from-memory, 2 PIO words, 8 bytes, ignored bits set (R1, R2, R6, R7)
        put_desc(32'h040, 32'h0, mk_cmd(2, 0, 1, 1, 2, 8, 1), 32'h400, 2, 32'hAB00_0000, 1);
        fill_buf(32'h400, 2, 32'h5A5A_0001, 1);
        load_ptr(32'h040);
        add_sema(1);
        wait_idle();
        drain_check("R1 R2 R7");
        chk(sema_count == 0, "R4 decrement on completion", sema_count, 0);
        chk(irq_pending == 1, "R11 pending set", irq_pending, 1);
        chk(irq == 0, "R11 irq masked by enable", irq, 0);

        // T2: interrupt enable and acknowledge (R11)
        @(posedge clk); #1 irq_en = 1;
        @(negedge clk);
        chk(irq == 1, "R11 irq when enabled", irq, 1);
        @(posedge clk); #1 irq_ack = 1;
        @(posedge clk); #1 irq_ack = 0;
        @(negedge clk);
        chk(irq_pending == 0 && irq == 0, "R11 ack clears", {irq_pending, irq}, 0);
        irq_en = 0;

        // T3: chained to-memory pair (R8, R10); 10 bytes -> 3 words, 4 bytes -> 1 word
        put_desc(32'h080, 32'h0C0, mk_cmd(1, 1, 0, 1, 0, 10, 0), 32'h600, 0, 0, 0);
        put_desc(32'h0C0, 32'h0,   mk_cmd(1, 0, 0, 1, 0, 4, 0),  32'h680, 0, 0, 0);
        in_cnt = 0;
        in_en = 1;
        load_ptr(32'h080);
        add_sema(2);
        wait_idle();
        in_en = 0;
        for (int i = 0; i < 3; i++)
            chk(dut_mem[(32'h600 >> 2) + i] == 32'hC0DE_0000 + i, "R8 write to memory",
                dut_mem[(32'h600 >> 2) + i], 32'hC0DE_0000 + i);
        chk(dut_mem[32'h680 >> 2] == 32'hC0DE_0003, "R10 linked descriptor ran",
            dut_mem[32'h680 >> 2], 32'hC0DE_0003);
        chk(wr_flag[(32'h600 >> 2) + 3] == 0, "R8 word count rounds up only to 3",
            wr_flag[(32'h600 >> 2) + 3], 0);
        chk(sema_count == 0, "R4 two decrements", sema_count, 0);

        // T4: linked pair with count of one stops at the link (R3, R10)
        put_desc(32'h100, 32'h140, mk_cmd(2, 1, 0, 1, 1, 4, 0), 32'h700, 1, 32'h7700_0000, 1);
        fill_buf(32'h700, 1, 32'h1234_0000, 1);
        put_desc(32'h140, 32'h0, mk_cmd(2, 0, 0, 1, 0, 8, 0), 32'h740, 0, 0, 0);
        load_ptr(32'h100);
        add_sema(1);
        wait_idle();
        drain_check("R3 first of pair");
        repeat (5) @(negedge clk);
        chk(!busy && !mem_req, "R3 no start at zero count", {busy, mem_req}, 0);
        fill_buf(32'h740, 2, 32'h4321_0000, 1);
        add_sema(1);
        wait_idle();
        drain_check("R10 resume at link");

        // T5: no decrement, kind none (R4, R9)
        put_desc(32'h180, 32'h0, mk_cmd(0, 0, 0, 0, 0, 8, 0), 32'h780, 0, 0, 0);
        load_ptr(32'h180);
        add_sema(1);
        wait_idle();
        chk(sema_count == 1, "R4 clear decrement flag keeps count", sema_count, 1);
        chk(wr_flag[32'h780 >> 2] == 0, "R9 kind none moves no data", wr_flag[32'h780 >> 2], 0);
        // zero-byte read with interrupt (R9)
        put_desc(32'h1C0, 32'h0, mk_cmd(2, 0, 1, 1, 0, 0, 0), 32'h7C0, 0, 0, 0);
        load_ptr(32'h1C0);
        wait_idle();
        chk(sema_count == 0 && irq_pending == 1, "R9 zero bytes still completes",
            {sema_count, irq_pending}, 9'h001);
        // sense kind with bytes: no stream (monitor flags any word)
        put_desc(32'h200, 32'h0, mk_cmd(3, 0, 0, 1, 0, 8, 0), 32'h7C0, 0, 0, 0);
        load_ptr(32'h200);
        add_sema(1);
        wait_idle();
        chk(sema_count == 0, "R9 sense completes", sema_count, 0);

        // T6: semaphore add and saturation (R5); channel disarmed so nothing runs
        add_sema(5);
        @(negedge clk);
        chk(sema_count == 5, "R5 add readback", sema_count, 5);
        add_sema(255);
        @(negedge clk);
        chk(sema_count == 8'hFF, "R5 saturation", sema_count, 8'hFF);
        chk(!busy, "R10 disarmed stays idle", busy, 0);
        @(posedge clk); #1 abort = 1;
        @(posedge clk); #1 abort = 0;
        @(negedge clk);
        chk(sema_count == 0, "R13 abort clears count", sema_count, 0);

        // T7: unaligned pointer is forced to alignment (R2)
        put_desc(32'h240, 32'h0, mk_cmd(2, 0, 0, 1, 1, 4, 0), 32'h800, 1, 32'h9900_0000, 1);
        fill_buf(32'h800, 1, 32'hFACE_0000, 1);
        load_ptr(32'h247);
        add_sema(1);
        wait_idle();
        drain_check("R2 aligned pointer");

        // T8: freeze in the middle of a read (R12)
        put_desc(32'h280, 32'h0, mk_cmd(2, 0, 0, 1, 0, 16, 0), 32'h880, 0, 0, 0);
        fill_buf(32'h880, 4, 32'hBEEF_0000, 1);
        load_ptr(32'h280);
        add_sema(1);
        repeat (6) @(posedge clk);
        #1 freeze = 1;
        begin
            int bad = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (mem_req || st_out_valid || pio_wr || !busy || sema_count != 1) bad++;
            end
            chk(bad == 0, "R12 frozen channel quiet and held", bad, 0);
        end
        @(posedge clk); #1 freeze = 0;
        wait_idle();
        drain_check("R12 resume after freeze");

        // T9: abort mid-run (R13)
        put_desc(32'h2C0, 32'h0, mk_cmd(2, 1, 0, 1, 0, 64, 0), 32'h900, 0, 0, 0);
        load_ptr(32'h2C0);
        add_sema(3);
        mon_quiet = 1;
        repeat (7) @(posedge clk);
        #1 abort = 1;
        @(posedge clk); #1 abort = 0;
        @(negedge clk);
        chk(!busy && sema_count == 0, "R13 abort to idle", {busy, sema_count}, 0);
        add_sema(1);
        repeat (5) @(negedge clk);
        chk(!busy && !mem_req, "R13 disarmed after abort", {busy, mem_req}, 0);
        mon_quiet = 0;

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule